// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block turns an active-low external interrupt pin, and optionally one active-low general-purpose port pin, into a single pending-interrupt latch and a request line to the CPU. Both inputs are first passed through a multi-flop synchronizer. A falling edge on either qualified source sets the latch. In edge-and-level mode, a low level also keeps the latch set. Software uses a small synchronous register bus to mask the request, choose the trigger mode, acknowledge the pending request, enable the port pin as a source, clear the port pin's own flag, and drive a pullup-disable output.

The port pin counts as a source only while the peripheral that shares it is disabled and its enable bit is set. The port pin also sets its own flag. While a debug break is active, acknowledge and flag-clear writes are ignored unless a break-clear-enable input permits them. A clear made during a break stays in effect after the break ends.

Top module: `extirq_latch_ctrl`

## Requirements
- R1: A falling edge on `irq_pin_n` is captured by a two-flop synchronizer. If the pin goes low just after rising edge 0, the latch sets at rising edge 3, and `cpu_irq` and the pending bit read 1 from then on.
- R2: The port pin is a source only while `periph_en`=0 and the port-enable bit (option register, address 1, bit 1) is 1. Its falling edge sets the latch and also sets the port flag (option register bit 2).
- R3: The mask bit (control register, address 0, bit 0) forces `cpu_irq` to 0 but does not stop the latch from setting. Clearing the mask raises `cpu_irq` for a latch that is still pending.
- R4: Writing 1 to the acknowledge bit (control register bit 2) clears the latch. The acknowledge bit always reads 0.
- R5: If an edge reaches the latch in the same cycle as an acknowledge write, the latch stays set.
- R6: With the mode bit (control register bit 1) at 0, a pin held low does not set the latch again after an acknowledge. With the mode bit at 1, a held low level keeps the latch set through acknowledge writes.
- R7: While `brk_active`=1 and `brk_clr_en`=0, acknowledge writes and port-flag clear writes leave the latch and the flag unchanged.
- R8: While `brk_active`=1 and `brk_clr_en`=1, an acknowledge write clears the latch, and the latch stays clear after `brk_active` falls.
- R9: Writing 1 to the port flag bit clears the flag. Writing 0 to it leaves the flag unchanged.
- R10: The pullup-disable bit (option register bit 0) can be written and read back and drives `pullup_dis`. It has no effect on `cpu_irq`.
- R11: The pending bit (control register bit 3) reads the latch state, whatever the mask.
- R12: After reset, `cpu_irq`=0, `pullup_dis`=0, and both registers read 0x00. Addresses 2 and 3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low |
| port_pin_n | input | 1 | Shared port pin, active low when used as a source |
| periph_en | input | 1 | Shared peripheral enabled; blocks the port pin as a source |
| brk_active | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Permits clears during break |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (qualified by bus_sel) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| pullup_dis | output | 1 | Pullup-disable control bit |

## Verification
The hardest case to reach is an acknowledge write that lands exactly in the cycle when a synchronized edge reaches the latch. The stimulus gets there by driving the pin low, counting two clock edges through the synchronizer, and then issuing the acknowledge so that it is captured on the third edge. Break protection of both the latch and the port flag is reached by setting a flag first and then issuing clears under each combination of break inputs. A long random phase then mixes pin toggles, peripheral-enable changes, break changes and register writes, and compares every cycle against a cycle-level reference model kept in the bench.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_OPT  = 2'd1;

  localparam int unsigned CTRL_MASK = 0;
  localparam int unsigned CTRL_MODE = 1;
  localparam int unsigned CTRL_ACK  = 2;
  localparam int unsigned CTRL_PEND = 3;

  localparam int unsigned OPT_PUD   = 0;
  localparam int unsigned OPT_PIE   = 1;
  localparam int unsigned OPT_PFLAG = 2;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic       mask;
    trig_mode_e mode;
    logic       pud;
    logic       pie;
  } irq_cfg_t;
endpackage

// File: rtl/extirq_rst_sync.sv
module extirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= sh_d;
    end

    assign q[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/extirq_src_qual.sv
module extirq_src_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_s,
  input  logic port_n_s,
  input  logic periph_en,
  input  logic port_ie,
  output logic any_act,
  output logic port_act,
  output logic any_edge,
  output logic port_edge
);
  logic prev_any_q, prev_port_q;
  logic prev_any_d, prev_port_d;
  logic pin_act;

  always_comb begin
    pin_act     = ~pin_n_s;
    port_act    = port_ie & ~periph_en & ~port_n_s;
    any_act     = pin_act | port_act;
    any_edge    = any_act & ~prev_any_q;
    port_edge   = port_act & ~prev_port_q;
    prev_any_d  = any_act;
    prev_port_d = port_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_any_q  <= 1'b0;
      prev_port_q <= 1'b0;
    end else begin
      prev_any_q  <= prev_any_d;
      prev_port_q <= prev_port_d;
    end
  end

  // R2: a port edge can only appear while the port source is qualified
  assert_port_edge_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en | ~port_ie) |-> ~port_edge);
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              brk_active,
  input  logic              brk_clr_en,
  input  logic              any_act,
  input  logic              port_act,
  input  logic              any_edge,
  input  logic              port_edge,
  output irq_cfg_t          cfg,
  output logic              latch,
  output logic              port_flag
);
  irq_cfg_t cfg_q, cfg_d;
  logic     cfg_ctrl_en, cfg_opt_en;
  logic     latch_q, latch_d;
  logic     flag_q, flag_d;
  logic     wr_ctrl, wr_opt, clr_ok;
  logic     ack_clr, flag_clr, lat_set, flag_set, level_mode;

  always_comb begin
    wr_ctrl    = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);
    wr_opt     = bus_sel & bus_wr & (bus_addr == ADDR_OPT);
    clr_ok     = ~brk_active | brk_clr_en;
    level_mode = (cfg_q.mode == TRIG_EDGE_LEVEL);

    ack_clr  = wr_ctrl & bus_wdata[CTRL_ACK] & clr_ok;
    flag_clr = wr_opt & bus_wdata[OPT_PFLAG] & clr_ok;
    lat_set  = any_edge | (level_mode & any_act);
    flag_set = port_edge | (level_mode & port_act);

    latch_d = lat_set | (latch_q & ~ack_clr);
    flag_d  = flag_set | (flag_q & ~flag_clr);

    cfg_ctrl_en = wr_ctrl;
    cfg_opt_en  = wr_opt;
    cfg_d       = cfg_q;
    if (cfg_ctrl_en) begin
      cfg_d.mask = bus_wdata[CTRL_MASK];
      cfg_d.mode = trig_mode_e'(bus_wdata[CTRL_MODE]);
    end
    if (cfg_opt_en) begin
      cfg_d.pud = bus_wdata[OPT_PUD];
      cfg_d.pie = bus_wdata[OPT_PIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '{mask: 1'b0, mode: TRIG_EDGE, pud: 1'b0, pie: 1'b0};
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cfg_ctrl_en || cfg_opt_en) cfg_q <= cfg_d;
      latch_q <= latch_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTRL_MASK] = cfg_q.mask;
        bus_rdata[CTRL_MODE] = cfg_q.mode;
        bus_rdata[CTRL_PEND] = latch_q;
      end
      ADDR_OPT: begin
        bus_rdata[OPT_PUD]   = cfg_q.pud;
        bus_rdata[OPT_PIE]   = cfg_q.pie;
        bus_rdata[OPT_PFLAG] = flag_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign latch     = latch_q;
  assign port_flag = flag_q;

  // R4: an acknowledge outside break, with no set source, clears the latch
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel & bus_wr & (bus_addr == ADDR_CTRL) & bus_wdata[CTRL_ACK] & ~brk_active
     & ~any_edge & ~(cfg_q.mode == TRIG_EDGE_LEVEL & any_act)) |=> ~latch_q);

  // R5: an arriving edge always leaves the latch set
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any_edge |=> latch_q);

  // R7: protected latch and flag hold during break
  assert_brk_hold_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active & ~brk_clr_en & latch_q) |=> latch_q);
  assert_brk_hold_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active & ~brk_clr_en & flag_q) |=> flag_q);
endmodule

// File: rtl/extirq_latch_ctrl.sv
module extirq_latch_ctrl
  import extirq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic              port_pin_n,
  input  logic              periph_en,
  input  logic              brk_active,
  input  logic              brk_clr_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq,
  output logic              pullup_dis
);
  localparam int unsigned N_SRC = 2;

  logic             rst_n_i;
  logic [N_SRC-1:0] raw_n, sync_n;
  logic             any_act, port_act, any_edge, port_edge;
  irq_cfg_t         cfg;
  logic             latch, port_flag;

  extirq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign raw_n = {port_pin_n, irq_pin_n};

  extirq_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (raw_n),
    .q     (sync_n)
  );

  extirq_src_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .pin_n_s   (sync_n[0]),
    .port_n_s  (sync_n[1]),
    .periph_en (periph_en),
    .port_ie   (cfg.pie),
    .any_act   (any_act),
    .port_act  (port_act),
    .any_edge  (any_edge),
    .port_edge (port_edge)
  );

  extirq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .brk_active (brk_active),
    .brk_clr_en (brk_clr_en),
    .any_act    (any_act),
    .port_act   (port_act),
    .any_edge   (any_edge),
    .port_edge  (port_edge),
    .cfg        (cfg),
    .latch      (latch),
    .port_flag  (port_flag)
  );

  assign cpu_irq    = latch & ~cfg.mask;
  assign pullup_dis = cfg.pud;

  // R1: the latch rises only after a synchronized source was active
  assert_rise_cause_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(latch) |-> $past(any_act));

  // R2: the port flag never rises from an unqualified port pin
  assert_port_gate_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (periph_en | ~cfg.pie) |=> ~$rose(port_flag));
endmodule

// File: tb/extirq_latch_ctrl_bench.sv
module extirq_latch_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_pin_n, port_pin_n, periph_en, brk_active, brk_clr_en;
  logic       bus_sel, bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       cpu_irq, pullup_dis;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  extirq_latch_ctrl u_extirq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pin_n(port_pin_n),
    .periph_en(periph_en), .brk_active(brk_active), .brk_clr_en(brk_clr_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .pullup_dis(pullup_dis)
  );

  // cycle-level reference model built from the requirements
  logic mp1, mp2, mq1, mq2, m_pa, m_pp;
  logic m_latch, m_flag, m_mask, m_mode, m_pud, m_pie;

  function automatic logic f_port(logic pie, logic pen, logic q);
    return pie & ~pen & ~q;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp1 <= 1'b1; mp2 <= 1'b1; mq1 <= 1'b1; mq2 <= 1'b1;
      m_pa <= 1'b0; m_pp <= 1'b0; m_latch <= 1'b0; m_flag <= 1'b0;
      m_mask <= 1'b0; m_mode <= 1'b0; m_pud <= 1'b0; m_pie <= 1'b0;
    end else begin
      logic pa, pp, okc, wc, wo;
      pp  = f_port(m_pie, periph_en, mq2);
      pa  = ~mp2 | pp;
      okc = ~brk_active | brk_clr_en;
      wc  = bus_sel & bus_wr & (bus_addr == 2'd0);
      wo  = bus_sel & bus_wr & (bus_addr == 2'd1);
      mp1 <= irq_pin_n; mp2 <= mp1; mq1 <= port_pin_n; mq2 <= mq1;
      m_pa <= pa; m_pp <= pp;
      m_latch <= (pa & ~m_pa) | (m_mode & pa) | (m_latch & ~(wc & bus_wdata[2] & okc));
      m_flag  <= (pp & ~m_pp) | (m_mode & pp) | (m_flag & ~(wo & bus_wdata[2] & okc));
      if (wc) begin m_mask <= bus_wdata[0]; m_mode <= bus_wdata[1]; end
      if (wo) begin m_pud <= bus_wdata[0]; m_pie <= bus_wdata[1]; end
    end
  end

  function automatic logic [7:0] f_read(logic [1:0] a);
    case (a)
      2'd0:    return {4'b0, m_latch, 1'b0, m_mode, m_mask};
      2'd1:    return {5'b0, m_flag, m_pie, m_pud};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_pin_n = 1'b1; port_pin_n = 1'b1; periph_en = 1'b0;
    brk_active = 1'b0; brk_clr_en = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(5);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240607));
    do_reset();

    // R12 reset state
    chk("R12 cpu_irq", {7'b0, cpu_irq}, 8'h00);
    chk("R12 pullup_dis", {7'b0, pullup_dis}, 8'h00);
    rd(2'd0, v); chk("R12 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R12 opt", v, 8'h00);
    rd(2'd3, v); chk("R12 unused addr", v, 8'h00);

    // R1 latency
    irq_pin_n = 1'b0;
    tick(2); chk("R1 not yet", {7'b0, cpu_irq}, 8'h00);
    tick(1); chk("R1 set", {7'b0, cpu_irq}, 8'h01);
    rd(2'd0, v); chk("R11 pend", v, 8'h08);
    irq_pin_n = 1'b1; tick(3);

    // R4 ack
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R4 ack clears, reads 0", v, 8'h00);
    chk("R4 cpu_irq", {7'b0, cpu_irq}, 8'h00);

    // R3 mask
    wr(2'd0, 8'h01);
    irq_pin_n = 1'b0; tick(4);
    chk("R3 masked", {7'b0, cpu_irq}, 8'h00);
    rd(2'd0, v); chk("R3 R11 pend under mask", v, 8'h09);
    wr(2'd0, 8'h00);
    chk("R3 unmask", {7'b0, cpu_irq}, 8'h01);
    irq_pin_n = 1'b1; tick(3);
    wr(2'd0, 8'h04);

    // R5 edge coincides with ack
    irq_pin_n = 1'b0; tick(2);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R5 edge wins", v, 8'h08);

    // R6 edge mode: held low does not re-latch
    wr(2'd0, 8'h04); tick(2);
    rd(2'd0, v); chk("R6 edge mode no relatch", v, 8'h00);
    // level mode
    wr(2'd0, 8'h02); tick(1);
    rd(2'd0, v); chk("R6 level sets", v, 8'h0A);
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R6 level holds through ack", v, 8'h0A);
    irq_pin_n = 1'b1; tick(3);
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R6 level released", v, 8'h02);
    wr(2'd0, 8'h00);

    // R7 / R8 break
    irq_pin_n = 1'b0; tick(4); irq_pin_n = 1'b1; tick(3);
    brk_active = 1'b1; brk_clr_en = 1'b0;
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R7 protected latch", v, 8'h08);
    brk_clr_en = 1'b1;
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R8 cleared in break", v, 8'h00);
    brk_active = 1'b0; brk_clr_en = 1'b0; tick(2);
    rd(2'd0, v); chk("R8 stays cleared", v, 8'h00);

    // R2 port gating
    port_pin_n = 1'b0; tick(4);
    chk("R2 disabled pin", {7'b0, cpu_irq}, 8'h00);
    port_pin_n = 1'b1; tick(3);
    wr(2'd1, 8'h02); periph_en = 1'b1;
    port_pin_n = 1'b0; tick(4);
    rd(2'd1, v); chk("R2 periph blocks", v, 8'h02);
    chk("R2 periph blocks irq", {7'b0, cpu_irq}, 8'h00);
    port_pin_n = 1'b1; tick(3); periph_en = 1'b0; tick(1);
    port_pin_n = 1'b0; tick(3);
    chk("R2 port irq", {7'b0, cpu_irq}, 8'h01);
    rd(2'd1, v); chk("R2 port flag", v, 8'h06);
    port_pin_n = 1'b1; tick(3);

    // R9 flag w1c
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R9 write 0 keeps", v, 8'h06);
    wr(2'd1, 8'h06);
    rd(2'd1, v); chk("R9 w1c", v, 8'h02);
    wr(2'd0, 8'h04);
    port_pin_n = 1'b0; tick(4); port_pin_n = 1'b1; tick(3);
    brk_active = 1'b1;
    wr(2'd1, 8'h06);
    rd(2'd1, v); chk("R7 protected flag", v, 8'h06);
    brk_active = 1'b0;
    wr(2'd1, 8'h06);
    rd(2'd1, v); chk("R9 clear after break", v, 8'h02);
    wr(2'd0, 8'h04);

    // R10 pullup bit
    wr(2'd1, 8'h01);
    chk("R10 pullup_dis", {7'b0, pullup_dis}, 8'h01);
    chk("R10 no irq effect", {7'b0, cpu_irq}, 8'h00);
    rd(2'd1, v); chk("R10 readback", v, 8'h01);

    // random phase against the reference model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r;
      chk("R1 R3 rnd cpu_irq", {7'b0, cpu_irq}, {7'b0, m_latch & ~m_mask});
      chk("R10 rnd pullup", {7'b0, pullup_dis}, {7'b0, m_pud});
      chk("R11 rnd read", bus_rdata, f_read(bus_addr));
      if ($urandom % 6 == 0) irq_pin_n = ~irq_pin_n;
      if ($urandom % 6 == 0) port_pin_n = ~port_pin_n;
      if ($urandom % 20 == 0) periph_en = ~periph_en;
      if ($urandom % 16 == 0) brk_active = ~brk_active;
      if ($urandom % 16 == 0) brk_clr_en = ~brk_clr_en;
      r = $urandom % 8;
      bus_addr = 2'($urandom % 4);
      bus_wdata = 8'($urandom);
      bus_sel = (r < 3);
      bus_wr  = (r < 3);
      if (r == 0) bus_addr = 2'd0;
      if (r == 1) bus_addr = 2'd1;
      if (r == 0 && ($urandom % 4 != 0)) bus_wdata[0] = 1'b0;
      if (r == 1) bus_wdata[1] = 1'b1;
      @(negedge clk);
      #1;
    end
    bus_sel = 1'b0; bus_wr = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule